// File: doc/BRIEF.md
# Supervisory Reset Controller with Edge-Serviced Watchdog

This block generates the reset for a processor from three fault sources. The first is a supply-good flag produced by an external threshold comparator. The second is an active-low manual reset request. The third is an internal watchdog, which trips when its service input stops toggling. All three are combined into a single reset. Once every source is quiet, the reset is held for a fixed number of clock cycles and then released.

The watchdog accepts either a rising or a falling edge of its service input as a service. It is frozen at zero for as long as reset is asserted, so the processor gets a complete timeout window after every release. Parameters set the following:
- the timeout length and the reset-pulse length, both in clock cycles;
- whether the watchdog exists at all;
- which of the two reset outputs, active-high and active-low, carries the reset. An output that is not selected is tied to its inactive level.

All inputs are assumed clean and already synchronised to the block clock.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, reset is asserted. If every source is inactive after `rst_n` rises, reset deasserts on exactly the PULSE_CYC-th rising clock edge after the release.
- R2: A low `supply_ok` sampled on a rising edge asserts reset after that edge and keeps it asserted while the flag stays low.
- R3: A low `mr_n` sampled on a rising edge asserts reset after that edge and keeps it asserted while the input stays low.
- R4: Reset deasserts on the PULSE_CYC-th rising edge that samples all sources inactive. When sources overlap, this count starts only after the last of them goes inactive.
- R5: A source that becomes active again during the hold period restarts the full PULSE_CYC count once it goes inactive.
- R6: With the watchdog enabled, suppose no service edge arrives after a release or after the last service edge. Reset then asserts on the (TIMEOUT_CYC+1)-th rising edge after that point and is held for PULSE_CYC edges, as in R4.
- R7: A change of `wdi` in either direction (0 to 1 or 1 to 0) between two rising edges counts as a service and restarts the timeout window.
- R8: While reset is asserted, the watchdog stays at zero. Toggles of `wdi` during reset have no effect, and a full TIMEOUT_CYC window starts at the release edge.
- R9: With WDOG_EN = 0, `wdi` is ignored and the block never asserts reset on its own while `supply_ok` and `mr_n` stay high.
- R10: With ACT_HI = 1, `rst_out` is 1 while reset is asserted; with ACT_HI = 0 it is held at 0. With ACT_LO = 1, `rst_out_n` is 0 while reset is asserted; with ACT_LO = 0 it is held at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| supply_ok | input | 1 | 1 when the supply is above threshold |
| mr_n | input | 1 | Manual reset request, active low |
| wdi | input | 1 | Watchdog service input, serviced by any edge |
| rst_out | output | 1 | Active-high reset (held 0 when ACT_HI = 0) |
| rst_out_n | output | 1 | Active-low reset (held 1 when ACT_LO = 0) |

## Verification
The assertions assume that `supply_ok`, `mr_n` and `wdi` are synchronous to `clk` and settle between rising edges. They also assume that the only way to start the block from a known state is `rst_n`. The stimulus respects this by changing every input only on falling clock edges. It releases `rst_n` on a falling edge as well, so that each rising edge sees one stable value and the edge counts in R4 to R8 are unambiguous. Stimulus rows are sized so that watchdog service edges always land inside the TIMEOUT_CYC window, except where a timeout is the intended result.

// File: rtl/sup_pkg.sv
`timescale 1ns/1ps
package sup_pkg;

  // One flag per reset cause, merged by the stretcher.
  typedef struct packed {
    logic supply_low;
    logic manual;
    logic wdog;
  } src_t;

  // Counter width able to hold values 0 .. n-1 (at least one bit).
  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/sup_edge_det.sv
`timescale 1ns/1ps
module sup_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic toggled
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= din;
  end

  assign toggled = din ^ prev_q;

endmodule

// File: rtl/sup_wdog.sv
`timescale 1ns/1ps
module sup_wdog #(
  parameter int unsigned TIMEOUT_CYC = 1600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic service,
  output logic fire
);

  localparam int unsigned W = sup_pkg::cnt_w(TIMEOUT_CYC);
  localparam logic [W-1:0] LAST = W'(TIMEOUT_CYC - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         fire_q, fire_d;
  logic         cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    fire_d = 1'b0;
    if (hold || service) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      fire_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      fire_q <= fire_d;
    end
  end

  assign fire = fire_q;

  // R8: counter is parked at zero while reset is asserted
  p_held_in_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt_q == '0));

  // R7: a service edge outside reset restarts the window
  p_service_restarts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (service && !hold) |=> (cnt_q == '0 && !fire_q));

  // R6: a trip only follows a counter that reached its last value
  p_fire_after_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fire_q) |-> ($past(cnt_q) == LAST && !$past(hold)));

  p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/sup_stretch.sv
`timescale 1ns/1ps
module sup_stretch #(
  parameter int unsigned PULSE_CYC = 200
) (
  input  logic           clk,
  input  logic           rst_n,
  input  sup_pkg::src_t  src,
  output logic           asserted
);

  localparam int unsigned W = sup_pkg::cnt_w(PULSE_CYC);
  localparam logic [W-1:0] LAST = W'(PULSE_CYC - 1);

  logic         any_src;
  logic         asrt_q, asrt_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign any_src = |src;

  always_comb begin
    asrt_d = asrt_q;
    cnt_d  = cnt_q;
    if (any_src) begin
      asrt_d = 1'b1;
      cnt_d  = '0;
    end else if (asrt_q) begin
      if (cnt_q == LAST) begin
        asrt_d = 1'b0;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign cnt_en = (cnt_d != cnt_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asrt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      asrt_q <= asrt_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign asserted = asrt_q;

  // R4: release only after a full quiet count
  p_release_full_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asrt_q) |-> ($past(cnt_q) == LAST && !$past(any_src)));

  // R5: a source seen during the hold period rewinds the count
  p_retrigger_rewinds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    any_src |=> (asrt_q && cnt_q == '0));

endmodule

// File: rtl/sup_reset_ctrl.sv
`timescale 1ns/1ps
module sup_reset_ctrl #(
  parameter int unsigned TIMEOUT_CYC = 1600,
  parameter int unsigned PULSE_CYC   = 200,
  parameter bit          WDOG_EN     = 1'b1,
  parameter bit          ACT_HI      = 1'b1,
  parameter bit          ACT_LO      = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdi,
  output logic rst_out,
  output logic rst_out_n
);

  sup_pkg::src_t src;
  logic          asserted;
  logic          wd_fire;

  assign src.supply_low = ~supply_ok;
  assign src.manual     = ~mr_n;
  assign src.wdog       = wd_fire;

  generate
    if (WDOG_EN) begin : g_wdog
      logic svc;
      sup_edge_det u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (wdi),
        .toggled (svc)
      );
      sup_wdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wdog (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (asserted),
        .service (svc),
        .fire    (wd_fire)
      );
    end else begin : g_no_wdog
      logic unused_wdi;
      assign unused_wdi = wdi;
      assign wd_fire    = 1'b0;
    end
  endgenerate

  sup_stretch #(.PULSE_CYC(PULSE_CYC)) u_stretch (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (src),
    .asserted (asserted)
  );

  generate
    if (ACT_HI) begin : g_hi
      assign rst_out = asserted;
    end else begin : g_hi_off
      assign rst_out = 1'b0;
    end
    if (ACT_LO) begin : g_lo
      assign rst_out_n = ~asserted;
    end else begin : g_lo_off
      assign rst_out_n = 1'b1;
    end
  endgenerate

  // R2: a low supply flag forces reset on the next edge
  p_supply_low_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> asserted);

  // R3: a held manual request forces reset on the next edge
  p_manual_asserts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mr_n |=> asserted);

  // R6: a watchdog trip reaches the reset on the following edge
  p_trip_asserts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> asserted);

endmodule

// File: tb/tb_sup_reset_ctrl.sv
`timescale 1ns/1ps
module tb_sup_reset_ctrl;

  localparam int unsigned T = 20;
  localparam int unsigned P = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic supply_ok, mr_n, wdi;
  logic rst_out, rst_out_n;
  logic nw_out, nw_out_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sup_reset_ctrl #(.TIMEOUT_CYC(T), .PULSE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .rst_out(rst_out), .rst_out_n(rst_out_n)
  );

  sup_reset_ctrl #(.TIMEOUT_CYC(T), .PULSE_CYC(P), .WDOG_EN(1'b0), .ACT_LO(1'b0)) dut_nowd (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mr_n(mr_n), .wdi(wdi),
    .rst_out(nw_out), .rst_out_n(nw_out_n)
  );

  typedef struct packed {
    logic       sup;
    logic       mr;
    logic       wd;
    logic [7:0] n;
    logic       exp;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b1, 1'b0, 8'd1,  1'b1},  // R2 supply drop
    '{1'b1, 1'b1, 1'b0, 8'd7,  1'b1},  // R4 still holding
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0},  // R4 release on 8th quiet edge
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1},  // R3 manual request
    '{1'b1, 1'b0, 1'b0, 8'd5,  1'b1},  // R3 held
    '{1'b1, 1'b1, 1'b0, 8'd4,  1'b1},  // R5 partway through hold
    '{1'b1, 1'b0, 1'b0, 8'd1,  1'b1},  // R5 retrigger
    '{1'b1, 1'b1, 1'b0, 8'd7,  1'b1},  // R5 full count restarted
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0},  // R5 release
    '{1'b1, 1'b1, 1'b1, 8'd15, 1'b0},  // R7 rising edge services
    '{1'b1, 1'b1, 1'b0, 8'd15, 1'b0},  // R7 falling edge services
    '{1'b1, 1'b1, 1'b0, 8'd5,  1'b0},  // R6 window nearly spent
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b0},  // R6 trip edge, reset not yet out
    '{1'b1, 1'b1, 1'b0, 8'd1,  1'b1},  // R6 reset on 21st edge
    '{1'b1, 1'b1, 1'b1, 8'd7,  1'b1},  // R8 toggle during reset ignored
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b0},  // R6 watchdog pulse length
    '{1'b1, 1'b1, 1'b1, 8'd20, 1'b0},  // R8 full window after release
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b1},  // R8 trip exactly after window
    '{1'b0, 1'b0, 1'b1, 8'd3,  1'b1},  // R4 two sources together
    '{1'b1, 1'b0, 1'b1, 8'd3,  1'b1},  // R4 manual still active
    '{1'b1, 1'b1, 1'b1, 8'd7,  1'b1},  // R4 count from last source
    '{1'b1, 1'b1, 1'b1, 8'd1,  1'b0}   // R4 release
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #800000;
    fails++;
    checks++;
    $display("FAIL watchdog: got hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1; wdi = 1'b0;
    step(3);
    chk("R1 reset hi", rst_out, 1'b1);
    chk("R1 reset lo", rst_out_n, 1'b0);
    chk("R10 nowd hi", nw_out, 1'b1);
    chk("R10 nowd lo tied", nw_out_n, 1'b1);
    rst_n = 1'b1;
    step(P - 1);
    chk("R1 held", rst_out, 1'b1);
    step(1);
    chk("R1 released", rst_out, 1'b0);
    chk("R10 lo released", rst_out_n, 1'b1);

    for (int i = 0; i < NV; i++) begin
      supply_ok = VEC[i].sup;
      mr_n      = VEC[i].mr;
      wdi       = VEC[i].wd;
      step(int'(VEC[i].n));
      chk($sformatf("vector %0d hi", i), rst_out, VEC[i].exp);
      chk($sformatf("R10 vector %0d lo", i), rst_out_n, ~VEC[i].exp);
    end

    // R9: no watchdog, static wdi, long idle never resets
    begin
      logic seen = 1'b0;
      for (int c = 0; c < 3 * int'(T); c++) begin
        step(1);
        seen = seen | nw_out;
      end
      chk("R9 no watchdog reset", seen, 1'b0);
      chk("R10 nowd lo stays 1", nw_out_n, 1'b1);
    end

    // R1: block reset mid-run asserts at once and repeats the full pulse
    rst_n = 1'b0;
    #1;
    chk("R1 async assert", rst_out, 1'b1);
    step(2);
    rst_n = 1'b1;
    step(P - 1);
    chk("R1 second hold", rst_out, 1'b1);
    step(1);
    chk("R1 second release", rst_out, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule